// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitized, active-low composite sync stream and picks out the vertical interval. Each stretch of sync-low time is measured in clock cycles by a counter that restarts on every sync transition. Ordinary line pulses are released long before the counter reaches the broad-pulse threshold. A broad pulse crosses that threshold and arms the vertical logic. The vertical output then starts when the broad pulse releases, which is the first serration gap. If sync stays low too long, a fallback timer starts the output instead. Once started, the output stays high for a fixed number of cycles and then drops.

The block also tracks line phase. A phase counter restarts on each accepted line leading edge. A leading edge that arrives well before a full line has passed is treated as a half-line pulse and ignored. When the vertical output starts, the block reads the phase. A start near mid-line marks one field and a start near line start marks the other, and the result is held in a field flag until the next vertical start. Every duration is a parameter in clock cycles. The sync input is retimed by a two-flop synchronizer before any edge is taken from it.

Top module: `vsync_field_det`

## Requirements
- R1: A sync-low pulse shorter than BROAD_CYC cycles never starts the vertical output.
- R2: A sync-low pulse of at least BROAD_CYC cycles arms vertical detection while the block is idle, and every armed interval produces exactly one vertical start.
- R3: When armed, if csync_n returns high (the first serration) the vertical output goes high 2 clock edges after the first edge that samples csync_n high.
- R4: When armed and csync_n stays low, the vertical output goes high BROAD_CYC+FALLBACK_CYC+1 edges after the first edge that sampled csync_n low.
- R5: The vertical output stays high for exactly VWIDTH_CYC cycles. Broad pulses that arrive while it is high neither extend it nor start another one.
- R6: field_odd changes only in the cycle in which vsync rises.
- R7: At a vertical start, let the phase be the number of cycles since the last accepted line leading edge, saturating at LINE_CYC. If LINE_CYC/4 <= phase < 3*LINE_CYC/4, field_odd becomes 0. Otherwise it becomes 1.
- R8: A falling edge of csync_n that arrives less than 3*LINE_CYC/4 cycles after the last accepted one does not restart the phase count (half-line rejection). The phase count never exceeds LINE_CYC.
- R9: A synchronous active-high reset drives vsync and field_odd to 0, disarms detection and saturates the phase count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Digitized composite sync, low during sync tips |
| vsync | output | 1 | Vertical sync pulse, active high |
| field_odd | output | 1 | Field flag, 1 for an odd field, updated at each vertical start |

## Verification
The bench builds the block with a 200-cycle line, a 40-cycle broad threshold, a 30-cycle fallback and a 450-cycle vertical width. At these values a full vertical interval, with half-line equalizing pulses, three broad pulses and serrations, fits in a few hundred cycles. Several fields can therefore run back to back with both line-aligned and mid-line vertical starts. The same settings put the fallback path, a pulse one cycle below the threshold and a pulse exactly at it within a short run. They also make the 450-cycle width outlast a broad train, so the ignore-while-active rule is exercised.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    // Vertical detection state
    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,
        VS_ARMED  = 2'd1,
        VS_ACTIVE = 2'd2
    } vs_state_e;

    // Retimed sync level and its transitions
    typedef struct packed {
        logic level;   // retimed csync_n
        logic fall;    // high-to-low transition this cycle
        logic rise;    // low-to-high transition this cycle
    } sync_ev_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // True when a phase value lies in the middle half of a line
    function automatic logic phase_is_mid(input int unsigned ph, input int unsigned line_len);
        return (ph >= line_len / 4) && (ph < (3 * line_len) / 4);
    endfunction

endpackage

// File: rtl/vsd_sync_edge.sv
module vsd_sync_edge
    import vsd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     csync_n,
    output sync_ev_t ev
);
    // Synchronizer stages plus one history flop for edge detection
    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
        end else begin
            shreg <= {shreg[SYNC_STAGES-1:0], csync_n};
        end
    end

    always_comb begin
        ev.level = shreg[SYNC_STAGES-1];
        ev.fall  = shreg[SYNC_STAGES] & ~shreg[SYNC_STAGES-1];
        ev.rise  = ~shreg[SYNC_STAGES] & shreg[SYNC_STAGES-1];
    end

endmodule

// File: rtl/vsd_width_meter.sv
module vsd_width_meter
    import vsd_pkg::*;
#(
    parameter int unsigned BROAD_CYC = 400
) (
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t ev,
    output logic     broad_hit
);
    localparam int unsigned RW      = $clog2(BROAD_CYC + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(BROAD_CYC);
    localparam logic [RW-1:0] RUN_HIT = RW'(BROAD_CYC - 1);

    // Cycles the retimed sync has been low; restarts on every transition
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (ev.fall) begin
            run <= RW'(1);
        end else if (ev.rise) begin
            run <= '0;
        end else if (!ev.level && run != RUN_MAX) begin
            run <= run + RW'(1);
        end
    end

    // Single-cycle strobe the moment a low stretch reaches the broad width
    assign broad_hit = !ev.level && !ev.fall && (run == RUN_HIT);

endmodule

// File: rtl/vsd_line_phase.sv
module vsd_line_phase #(
    parameter int unsigned LINE_CYC = 1716
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lead_edge,
    output logic [$clog2(LINE_CYC+1)-1:0] phase
);
    localparam int unsigned PW = $clog2(LINE_CYC + 1);
    localparam logic [PW-1:0] PH_MAX  = PW'(LINE_CYC);
    localparam logic [PW-1:0] PH_GATE = PW'((3 * LINE_CYC) / 4);

    // Leading edges inside the gate window are half-line pulses and are skipped
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_MAX;
        end else if (lead_edge && phase >= PH_GATE) begin
            phase <= '0;
        end else if (phase != PH_MAX) begin
            phase <= phase + PW'(1);
        end
    end

endmodule

// File: rtl/vsd_vert_ctrl.sv
module vsd_vert_ctrl
    import vsd_pkg::*;
#(
    parameter int unsigned LINE_CYC     = 1716,
    parameter int unsigned FALLBACK_CYC = 600,
    parameter int unsigned VWIDTH_CYC   = 5148
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          broad_hit,
    input  logic                          serration,
    input  logic [$clog2(LINE_CYC+1)-1:0] phase,
    output vs_state_e                     state,
    output logic                          field_odd
);
    localparam int unsigned TW = $clog2(max_u(FALLBACK_CYC, VWIDTH_CYC) + 1);
    localparam logic [TW-1:0] FB_LAST = TW'(FALLBACK_CYC - 1);
    localparam logic [TW-1:0] VW_LAST = TW'(VWIDTH_CYC - 1);

    // One timer serves the fallback wait and the pulse width
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= VS_IDLE;
            tcnt      <= '0;
            field_odd <= 1'b0;
        end else begin
            case (state)
                VS_IDLE: begin
                    if (broad_hit) begin
                        state <= VS_ARMED;
                        tcnt  <= '0;
                    end
                end
                VS_ARMED: begin
                    if (serration || tcnt == FB_LAST) begin
                        state     <= VS_ACTIVE;
                        tcnt      <= '0;
                        field_odd <= !phase_is_mid(32'(phase), LINE_CYC);
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                VS_ACTIVE: begin
                    if (tcnt == VW_LAST) begin
                        state <= VS_IDLE;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                default: begin
                    state <= VS_IDLE;
                    tcnt  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det
    import vsd_pkg::*;
#(
    parameter int unsigned LINE_CYC     = 1716,
    parameter int unsigned BROAD_CYC    = 400,
    parameter int unsigned FALLBACK_CYC = 600,
    parameter int unsigned VWIDTH_CYC   = 5148
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_n,
    output logic vsync,
    output logic field_odd
);
    localparam int unsigned PW          = $clog2(LINE_CYC + 1);
    localparam int unsigned SYNC_STAGES = 2;

    sync_ev_t      ev;
    logic          broad_hit;
    logic [PW-1:0] line_ph;
    vs_state_e     vstate;

    vsd_sync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .csync_n (csync_n),
        .ev      (ev)
    );

    vsd_width_meter #(
        .BROAD_CYC(BROAD_CYC)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .broad_hit (broad_hit)
    );

    vsd_line_phase #(
        .LINE_CYC(LINE_CYC)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .lead_edge (ev.fall),
        .phase     (line_ph)
    );

    vsd_vert_ctrl #(
        .LINE_CYC     (LINE_CYC),
        .FALLBACK_CYC (FALLBACK_CYC),
        .VWIDTH_CYC   (VWIDTH_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .broad_hit (broad_hit),
        .serration (ev.rise),
        .phase     (line_ph),
        .state     (vstate),
        .field_odd (field_odd)
    );

    assign vsync = (vstate == VS_ACTIVE);

endmodule

// File: rtl/vsync_field_det_chk.sv
module vsync_field_det_chk
    import vsd_pkg::*;
#(
    parameter int unsigned LINE_CYC   = 1716,
    parameter int unsigned VWIDTH_CYC = 5148
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          vsync,
    input logic                          field_odd,
    input logic                          broad_hit,
    input vs_state_e                     vstate,
    input logic [$clog2(LINE_CYC+1)-1:0] line_ph
);
    localparam int unsigned PW = $clog2(LINE_CYC + 1);
    localparam logic [PW-1:0] PH_MAX = PW'(LINE_CYC);
    localparam logic [31:0]   VW_LEN = 32'(VWIDTH_CYC);

    // Length of the current high run of vsync
    logic [31:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst)        hi_len <= '0;
        else if (vsync) hi_len <= hi_len + 32'd1;
        else            hi_len <= '0;
    end

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |-> (hi_len == VW_LEN));

    assert_pulse_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        vsync |-> (hi_len < VW_LEN));

    assert_field_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$rose(vsync) |-> $stable(field_odd));

    assert_start_after_arm_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> ($past(vstate) == VS_ARMED));

    assert_arm_needs_broad_R2: assert property (@(posedge clk) disable iff (rst)
        (vstate == VS_ARMED && $past(vstate) == VS_IDLE) |-> $past(broad_hit));

    assert_phase_bound_R8: assert property (@(posedge clk) disable iff (rst)
        line_ph <= PH_MAX);

    assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vsync && !field_odd && line_ph == PH_MAX));

endmodule

bind vsync_field_det vsync_field_det_chk #(
    .LINE_CYC   (LINE_CYC),
    .VWIDTH_CYC (VWIDTH_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vsync     (vsync),
    .field_odd (field_odd),
    .broad_hit (broad_hit),
    .vstate    (vstate),
    .line_ph   (line_ph)
);

// File: tb/vsync_field_det_bench.sv
module vsync_field_det_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LINE  = 200;
    localparam int BROAD = 40;
    localparam int FB    = 30;
    localparam int VW    = 450;
    localparam int GATE  = (3 * LINE) / 4;
    localparam int QTR   = LINE / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csync_n = 1'b1;
    logic vsync;
    logic field_odd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsync_field_det #(
        .LINE_CYC     (LINE),
        .BROAD_CYC    (BROAD),
        .FALLBACK_CYC (FB),
        .VWIDTH_CYC   (VW)
    ) u_vsync_field_det (
        .clk       (clk),
        .rst       (rst),
        .csync_n   (csync_n),
        .vsync     (vsync),
        .field_odd (field_odd)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     tag, what, cyc, act, exp);
        end
    endtask

    // Scoreboard of expected vertical starts
    typedef struct {
        int    start;
        bit    odd;
        string stag;
        string ftag;
    } exp_t;
    exp_t q[$];
    exp_t cur;

    // Independent model state
    int last_acc = -1;   // drive cycle of last accepted leading edge
    int vend = 0;        // cycle from which the model is idle again

    // Driver: one sync-low pulse followed by a high gap
    task automatic pulse(input int low_w, input int high_w, input string ftag);
        int n, ph, s, pha;
        n  = cyc;
        ph = (last_acc < 0) ? LINE : n - last_acc - 1;
        if (ph > LINE) ph = LINE;
        if (ph >= GATE) last_acc = n;
        if (low_w >= BROAD && n + BROAD + 1 >= vend) begin
            s = n + low_w + 3;
            if (n + BROAD + 2 + FB < s) s = n + BROAD + 2 + FB;
            pha = s - last_acc - 4;
            if (pha > LINE) pha = LINE;
            q.push_back('{s, !((pha >= QTR) && (pha < GATE)),
                          (s == n + low_w + 3) ? "R3" : "R4", ftag});
            vend = s + VW;
        end
        csync_n = 1'b0;
        repeat (low_w) @(negedge clk);
        csync_n = 1'b1;
        repeat (high_w) @(negedge clk);
    endtask

    task automatic lines(input int count);
        for (int i = 0; i < count; i++) pulse(15, LINE - 15, "R7");
    endtask

    task automatic equalizing(input int count);
        for (int i = 0; i < count; i++) pulse(7, LINE / 2 - 7, "R8");
    endtask

    task automatic broad_train(input string ftag);
        for (int i = 0; i < 3; i++) pulse(60, LINE / 2 - 60, ftag);
    endtask

    // Monitor
    bit pv = 1'b0;
    bit pf = 1'b0;
    int hl = 0;
    int stray_field = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (vsync && !pv) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1", "unexpected vertical start", 1, 0);
                end else begin
                    cur = q.pop_front();
                    check(cyc == cur.start, cur.stag, "vertical start cycle", cyc, cur.start);
                    check(field_odd == cur.odd, cur.ftag, "field flag", int'(field_odd), int'(cur.odd));
                end
                check(stray_field == 0, "R6", "field changes outside starts", stray_field, 0);
                hl = 1;
            end else begin
                if (field_odd != pf) stray_field++;
                if (vsync) hl++;
                else if (pv) check(hl == VW, "R5", "vertical width", hl, VW);
            end
            pv = vsync;
            pf = field_odd;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(vsync == 1'b0, "R9", "vsync in reset", int'(vsync), 0);
        rst = 1'b0;
        @(negedge clk);
        check(vsync == 1'b0, "R9", "vsync after reset", int'(vsync), 0);
        check(field_odd == 1'b0, "R9", "field after reset", int'(field_odd), 0);

        // Plain lines, then a pulse one cycle short of broad
        lines(4);
        check(vsync == 1'b0, "R1", "no start on line pulses", int'(vsync), 0);
        pulse(BROAD - 1, LINE - (BROAD - 1), "R1");
        lines(2);
        check(vsync == 1'b0, "R1", "no start below threshold", int'(vsync), 0);
        check(q.size() == 0, "R1", "no expected starts queued", q.size(), 0);

        // Line-aligned vertical interval: start near mid-line
        equalizing(4);
        broad_train("R7");
        equalizing(4);
        lines(4);

        // Mid-line vertical interval: half-line pulses must be skipped
        equalizing(5);
        broad_train("R8");
        equalizing(5);
        lines(4);

        // Line-aligned again: flag must flip back
        equalizing(4);
        broad_train("R7");
        equalizing(4);
        lines(4);

        // No serration: fallback timer starts the output
        pulse(100, LINE - 100, "R4");
        lines(4);

        // Exactly at threshold arms detection
        pulse(BROAD, LINE - BROAD, "R2");
        lines(4);

        repeat (VW + 50) @(negedge clk);
        check(q.size() == 0, "R2", "every armed interval started", q.size(), 0);
        check(vsync == 1'b0, "R5", "output low after train", int'(vsync), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule